// File: doc/BRIEF.md
# Serial Flash Maintenance Command Sequencer

This block sits on the host side of a serial flash link and runs one of three maintenance operations on request: write a page of main memory from the device's buffer without erasing it first, erase a single page, or erase an aligned group of eight pages. The host presents an operation code, a target number and a page-geometry select, then pulses a start strobe.

The sequencer captures the request and builds a four-byte frame from it: an opcode and a 24-bit address whose layout depends on both the operation and the geometry. It shifts the frame out most significant bit first on a divided serial clock and then releases chip select, which is what launches the self-timed operation inside the flash. After a short gap it selects the device again, sends a status-read opcode and keeps clocking status bytes with chip select held low until the ready bit comes back. It then releases the device and pulses done. If too many busy reads accumulate, it gives up, flags an error and still pulses done.

Top module: `flash_cmd_seq`

## Requirements
- R1: The first byte of the command frame is 0x88 for operation code 0 (program from buffer without erase), 0x81 for code 1 (page erase) and 0x50 for code 2 (eight-page erase).
- R2: With `geom256_i` low (264-byte pages), codes 0 and 1 send the 24-bit address as the 10-bit `target_i` in address bits 18..9, all other bits zero.
- R3: With `geom256_i` high (256-byte pages), codes 0 and 1 send `target_i` in address bits 17..8, all other bits zero.
- R4: Code 2 takes the block number from `target_i[6:0]` and sends it in address bits 18..12 with 264-byte pages and in bits 17..11 with 256-byte pages, all other bits zero.
- R5: Bits leave MSB first on `mosi_o`, which changes only while `sck_o` is low; `sck_o` idles low and is low whenever `cs_n_o` is high.
- R6: Chip select covers exactly 32 rising clock edges for the command frame and then goes high, which starts the device operation.
- R7: After a gap with chip select high, the block sends status opcode `STATUS_OPC` (default 0xD7) and reads status bytes under one continuous chip-select low period until bit 7 of a status byte is 1; it then raises chip select and pulses `done_o` for exactly one cycle.
- R8: A start is accepted only when the block is idle and the operation code is 0, 1 or 2; a start while busy or with code 3 has no effect.
- R9: If the number of busy status reads reaches `timeout_i` (a value of 0 counts as 1), polling stops, chip select rises, `err_o` goes high with `done_o`, and `err_o` stays high until the next accepted start.
- R10: After reset `cs_n_o` is 1 and `sck_o`, `busy_o`, `done_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation: 0 program, 1 page erase, 2 block erase |
| target_i | input | 10 | Page number, or block number in bits 6..0 |
| geom256_i | input | 1 | 1 selects 256-byte page geometry, 0 selects 264-byte |
| timeout_i | input | 16 | Maximum busy status reads |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Polling timeout flag |

## Verification
The bound checker watches the serial line discipline every cycle: the clock stays low outside chip select, data holds steady while the clock is high, done is a single cycle that ends a busy period, a rising error flag coincides with done, and busy only begins after a start strobe. Frame contents, the address packing for each operation and geometry, the count of clock edges under chip select, the number of status bytes read before ready or timeout, and the rejection of starts while busy or with the unused code can only be shown by the bench's device model decoding the link across whole scenarios.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int PAGE_W  = 10;
    localparam int BLOCK_W = 7;
    localparam int ADDR_W  = 24;
    localparam int FRAME_W = 8 + ADDR_W;
    localparam int FRAME_BYTES = FRAME_W / 8;

    typedef enum logic [1:0] {
        OP_PROG_NOERASE = 2'd0,
        OP_PAGE_ERASE   = 2'd1,
        OP_BLOCK_ERASE  = 2'd2,
        OP_RESERVED     = 2'd3
    } flash_op_e;

    localparam logic [7:0] OPC_PROG_NOERASE = 8'h88;
    localparam logic [7:0] OPC_PAGE_ERASE   = 8'h81;
    localparam logic [7:0] OPC_BLOCK_ERASE  = 8'h50;

    typedef struct packed {
        flash_op_e         op;
        logic [PAGE_W-1:0] target;
        logic              geom256;
    } flash_req_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_POLL_OP,
        ST_POLL_RD
    } seq_state_e;

    function automatic logic [7:0] opcode_of(flash_op_e op);
        case (op)
            OP_PROG_NOERASE: return OPC_PROG_NOERASE;
            OP_PAGE_ERASE:   return OPC_PAGE_ERASE;
            default:         return OPC_BLOCK_ERASE;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] pack_addr(flash_req_t r);
        logic [BLOCK_W-1:0] blk;
        blk = r.target[BLOCK_W-1:0];
        if (r.op == OP_BLOCK_ERASE) begin
            if (r.geom256) return {6'b0, blk, 11'b0};
            else           return {5'b0, blk, 12'b0};
        end else begin
            if (r.geom256) return {6'b0, r.target, 8'b0};
            else           return {5'b0, r.target, 9'b0};
        end
    endfunction

    function automatic logic [7:0] frame_byte(logic [FRAME_W-1:0] f, logic [1:0] idx);
        case (idx)
            2'd0:    return f[31:24];
            2'd1:    return f[23:16];
            2'd2:    return f[15:8];
            default: return f[7:0];
        endcase
    endfunction

endpackage

// File: rtl/flash_frame_build.sv
module flash_frame_build
    import flash_seq_pkg::*;
(
    input  flash_req_t         req_i,
    output logic [FRAME_W-1:0] frame_o
);
    always_comb begin
        frame_o = {opcode_of(req_i.op), pack_addr(req_i)};
    end
endmodule

// File: rtl/flash_byte_shifter.sv
module flash_byte_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       rx_msb_o,
    output logic       done_o
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic             active_q;
    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_q;
    logic             sck_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i && !active_q) begin
                active_q <= 1'b1;
                tx_q     <= tx_i;
                bit_q    <= '0;
                div_q    <= '0;
                sck_q    <= 1'b0;
            end else if (active_q) begin
                if (div_q == DIV_LAST) begin
                    div_q <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_q  <= {rx_q[6:0], miso_i};
                    end else begin
                        sck_q <= 1'b0;
                        if (bit_q == 3'd7) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            tx_q  <= {tx_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
        end
    end

    assign sck_o    = sck_q;
    assign mosi_o   = tx_q[7];
    assign rx_msb_o = rx_q[7];
    assign done_o   = done_q;
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int         GAP_CYC    = 4,
    parameter logic [7:0] STATUS_OPC = 8'hD7,
    parameter int         TMO_W      = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [1:0]         op_i,
    input  logic [PAGE_W-1:0]  target_i,
    input  logic               geom256_i,
    input  logic [TMO_W-1:0]   timeout_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               sh_done_i,
    input  logic               sh_rx_msb_i,
    output flash_req_t         req_o,
    output logic               sh_go_o,
    output logic [7:0]         sh_tx_o,
    output logic               cs_n_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);
    localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

    seq_state_e         state_q;
    flash_req_t         req_q;
    logic [TMO_W-1:0]   tmo_q;
    logic [TMO_W-1:0]   poll_q;
    logic [GAP_W-1:0]   gap_q;
    logic [1:0]         idx_q;
    logic               launch_q;
    logic               go_q;
    logic [7:0]         tx_q;
    logic               cs_n_q;
    logic               done_q;
    logic               err_q;

    logic               accept;
    logic [TMO_W:0]     busy_seen;
    logic [TMO_W:0]     tmo_limit;

    assign accept    = start_i && (state_q == ST_IDLE) && (op_i != 2'd3);
    assign busy_seen = {1'b0, poll_q} + (TMO_W+1)'(1);
    assign tmo_limit = (tmo_q == '0) ? (TMO_W+1)'(1) : {1'b0, tmo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            tmo_q    <= '0;
            poll_q   <= '0;
            gap_q    <= '0;
            idx_q    <= '0;
            launch_q <= 1'b0;
            go_q     <= 1'b0;
            tx_q     <= '0;
            cs_n_q   <= 1'b1;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        req_q    <= '{op: flash_op_e'(op_i), target: target_i, geom256: geom256_i};
                        tmo_q    <= timeout_i;
                        err_q    <= 1'b0;
                        cs_n_q   <= 1'b0;
                        idx_q    <= '0;
                        launch_q <= 1'b1;
                        state_q  <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (launch_q) begin
                        go_q     <= 1'b1;
                        tx_q     <= frame_byte(frame_i, idx_q);
                        launch_q <= 1'b0;
                    end else if (sh_done_i) begin
                        if (idx_q == 2'(FRAME_BYTES - 1)) begin
                            cs_n_q  <= 1'b1;
                            gap_q   <= '0;
                            state_q <= ST_GAP;
                        end else begin
                            idx_q    <= idx_q + 2'd1;
                            launch_q <= 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_q == GAP_LAST) begin
                        cs_n_q   <= 1'b0;
                        poll_q   <= '0;
                        launch_q <= 1'b1;
                        state_q  <= ST_POLL_OP;
                    end else begin
                        gap_q <= gap_q + GAP_W'(1);
                    end
                end
                ST_POLL_OP: begin
                    if (launch_q) begin
                        go_q     <= 1'b1;
                        tx_q     <= STATUS_OPC;
                        launch_q <= 1'b0;
                    end else if (sh_done_i) begin
                        launch_q <= 1'b1;
                        state_q  <= ST_POLL_RD;
                    end
                end
                ST_POLL_RD: begin
                    if (launch_q) begin
                        go_q     <= 1'b1;
                        tx_q     <= 8'h00;
                        launch_q <= 1'b0;
                    end else if (sh_done_i) begin
                        if (sh_rx_msb_i) begin
                            cs_n_q  <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (busy_seen >= tmo_limit) begin
                            cs_n_q  <= 1'b1;
                            done_q  <= 1'b1;
                            err_q   <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            poll_q   <= poll_q + TMO_W'(1);
                            launch_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_o   = req_q;
    assign sh_go_o = go_q;
    assign sh_tx_o = tx_q;
    assign cs_n_o  = cs_n_q;
    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;
    assign err_o   = err_q;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int         HALF_DIV   = 2,
    parameter int         GAP_CYC    = 4,
    parameter logic [7:0] STATUS_OPC = 8'hD7,
    parameter int         TMO_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [9:0]        target_i,
    input  logic              geom256_i,
    input  logic [TMO_W-1:0]  timeout_i,
    output logic              sck_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    flash_req_t         req;
    logic [FRAME_W-1:0] frame;
    logic               sh_go;
    logic [7:0]         sh_tx;
    logic               sh_done;
    logic               sh_rx_msb;

    flash_frame_build frame_i (
        .req_i   (req),
        .frame_o (frame)
    );

    flash_seq_ctrl #(
        .GAP_CYC    (GAP_CYC),
        .STATUS_OPC (STATUS_OPC),
        .TMO_W      (TMO_W)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .op_i        (op_i),
        .target_i    (target_i),
        .geom256_i   (geom256_i),
        .timeout_i   (timeout_i),
        .frame_i     (frame),
        .sh_done_i   (sh_done),
        .sh_rx_msb_i (sh_rx_msb),
        .req_o       (req),
        .sh_go_o     (sh_go),
        .sh_tx_o     (sh_tx),
        .cs_n_o      (cs_n_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    flash_byte_shifter #(
        .HALF_DIV (HALF_DIV)
    ) shift_i (
        .clk      (clk),
        .rst      (rst),
        .go_i     (sh_go),
        .tx_i     (sh_tx),
        .miso_i   (miso_i),
        .sck_o    (sck_o),
        .mosi_o   (mosi_o),
        .rx_msb_o (sh_rx_msb),
        .done_o   (sh_done)
    );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       sck_o,
    input logic       cs_n_o,
    input logic       mosi_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o
);
    // R5
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sck_o);

    // R5
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    // R8
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> done_o);

    // R10
    idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> cs_n_o);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .sck_o   (sck_o),
    .cs_n_o  (cs_n_o),
    .mosi_o  (mosi_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  op;
    logic [9:0]  target;
    logic        geom256;
    logic [15:0] timeout;
    logic        sck, cs_n, mosi, miso;
    logic        busy, done, err;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq dut_i (
        .clk (clk), .rst (rst), .start_i (start), .op_i (op),
        .target_i (target), .geom256_i (geom256), .timeout_i (timeout),
        .sck_o (sck), .cs_n_o (cs_n), .mosi_o (mosi), .miso_i (miso),
        .busy_o (busy), .done_o (done), .err_o (err)
    );

    // device model, sees outputs one clock late
    logic        p_sck = 1'b0, p_cs = 1'b1;
    logic [31:0] m_sr;
    int          m_bits;
    logic [7:0]  m_op, m_stat;
    int          m_busy_left = 0;
    int          next_busy = 0;
    int          frames = 0, polls = 0, poll_bits = 0, frame_bits = 0;
    logic [31:0] last_frame = '0;

    always @(posedge clk) begin
        if (rst) begin
            miso <= 1'b0;
        end else begin
            if (p_cs && !cs_n) begin
                m_bits = 0; m_sr = '0; m_op = '0;
            end
            if (!cs_n && !p_sck && sck) begin
                if (m_bits < 32) m_sr = {m_sr[30:0], mosi};
                m_bits++;
                if (m_bits == 8) m_op = m_sr[7:0];
            end
            if (!cs_n && p_sck && !sck && m_bits >= 8 && m_op == 8'hD7) begin
                if (((m_bits - 8) % 8) == 0) begin
                    m_stat = (m_busy_left == 0) ? 8'h9D : 8'h6E;
                    if (m_busy_left > 0) m_busy_left--;
                end
                miso <= m_stat[7 - ((m_bits - 8) % 8)];
            end
            if (!p_cs && cs_n) begin
                if (m_op == 8'hD7) begin
                    polls++; poll_bits = m_bits;
                end else begin
                    frames++; frame_bits = m_bits; last_frame = m_sr;
                    m_busy_left = next_busy;
                end
            end
            p_sck = sck;
            p_cs  = cs_n;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input logic [1:0] o, input logic [9:0] t, input logic g);
        logic [7:0]  opc;
        logic [23:0] a;
        opc = (o == 2'd0) ? 8'h88 : (o == 2'd1) ? 8'h81 : 8'h50;
        if (o == 2'd2) a = g ? (24'(t[6:0]) << 11) : (24'(t[6:0]) << 12);
        else           a = g ? (24'(t) << 8) : (24'(t) << 9);
        return {opc, a};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_op(input logic [1:0] o, input logic [9:0] t, input logic g,
                          input int nbusy, input int tmo, input bit poke);
        int f0, p0, eff, exp_bytes, n;
        bit exp_err;
        f0 = frames; p0 = polls;
        eff = (tmo == 0) ? 1 : tmo;
        exp_err = (nbusy >= eff);
        exp_bytes = exp_err ? eff : nbusy + 1;
        next_busy = nbusy;
        @(negedge clk);
        op = o; target = t; geom256 = g; timeout = 16'(tmo); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done) begin
            @(negedge clk);
            n++;
            if (poke && n == 40) begin
                op = 2'd1; target = ~t; geom256 = ~g; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        // R7 R9: done with err state, bus released
        check(err == exp_err, "R9 err at done", err, exp_err);
        check(!busy, "R7 idle at done", busy, 0);
        @(negedge clk);
        check(!done, "R7 done one cycle", done, 0);
        check(err == exp_err, "R9 err held", err, exp_err);
        @(negedge clk);
        // R8: exactly one command frame and one poll session
        check(frames == f0 + 1, "R8 one frame per op", frames - f0, 1);
        check(polls == p0 + 1, "R7 one poll session", polls - p0, 1);
        // R6
        check(frame_bits == 32, "R6 command clocks", frame_bits, 32);
        // R1 R2 R3 R4
        if (o == 2'd2)
            check(last_frame == exp_frame(o, t, g), "R4 block frame", last_frame, exp_frame(o, t, g));
        else if (g)
            check(last_frame == exp_frame(o, t, g), "R3 page frame 256", last_frame, exp_frame(o, t, g));
        else
            check(last_frame == exp_frame(o, t, g), "R2 page frame 264", last_frame, exp_frame(o, t, g));
        check(last_frame[31:24] == exp_frame(o, t, g)[31:24], "R1 opcode", last_frame[31:24], exp_frame(o, t, g)[31:24]);
        // R7 R9: status bytes clocked
        check(poll_bits == 8 + 8 * exp_bytes, "R7 poll length", poll_bits, 8 + 8 * exp_bytes);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; op = '0; target = '0; geom256 = 1'b0; timeout = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        check(cs_n && !sck && !busy && !done && !err, "R10 reset state",
              {cs_n, sck, busy, done, err}, 5'b10000);

        // directed corners
        run_op(2'd0, 10'h3FF, 1'b0, 0, 4, 1'b0);
        run_op(2'd1, 10'h3FF, 1'b1, 2, 4, 1'b0);
        run_op(2'd2, 10'h07F, 1'b0, 1, 4, 1'b0);
        run_op(2'd2, 10'h3C5, 1'b1, 0, 4, 1'b0);
        run_op(2'd1, 10'h001, 1'b0, 3, 3, 1'b0);   // R9 timeout at limit
        run_op(2'd0, 10'h200, 1'b1, 1, 0, 1'b0);   // R9 zero timeout
        run_op(2'd0, 10'h155, 1'b0, 2, 5, 1'b1);   // R8 start while busy

        // R8: reserved code ignored while idle
        begin
            int f0;
            f0 = frames;
            @(negedge clk);
            op = 2'd3; target = 10'h2AA; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (60) @(negedge clk);
            check(!busy && cs_n, "R8 reserved code idle", {busy, cs_n}, 2'b01);
            check(frames == f0, "R8 reserved code no frame", frames - f0, 0);
        end
        // R9: err cleared by next accepted start
        run_op(2'd1, 10'h011, 1'b0, 4, 2, 1'b0);
        @(negedge clk);
        op = 2'd0; target = 10'h0F0; geom256 = 1'b1; timeout = 16'd8; next_busy = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!err, "R9 err cleared on accept", err, 0);
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);

        // constrained random
        for (int i = 0; i < 30; i++) begin
            logic [1:0] ro;
            int rb, rt;
            ro = 2'($urandom_range(0, 2));
            rb = $urandom_range(0, 5);
            rt = $urandom_range(0, 6);
            run_op(ro, 10'($urandom), 1'($urandom), rb, rt, (i % 7) == 3);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule